// File: doc/BRIEF.md
# Dual-Speed CPU Clock Generator

This block derives three clocks from one selected source: a CPU clock that runs at full or reduced speed, a 50%-duty companion of that CPU clock, and a peripheral clock whose rate never changes. Everything lives in the fabric clock domain `clk`. The source oscillation arrives as a clock-enable pulse train, and each enable pulse stands for one half-period of the source. Counting half-periods lets a divide-by-three output carry a true 50%-duty companion. In this text a "tick" means a `clk` edge at which the selected enable is high.

Two enables come in: one from the crystal path and one from an external clock input. A registered strap picks which one drives the dividers. A buffered square wave of the crystal path is always available, whichever source is picked. A software-driven speed input selects fast or slow operation. It is synchronised first, and it takes effect only at a tick that also moves the peripheral clock. At that tick the CPU clock pair restarts its present phase using the new speed's lengths, so neither output is clipped and the pair keeps its order of edges.

Top module: `dual_speed_clkgen`

## Requirements
- R1: `per_clk` toggles every 6 ticks, giving 6 ticks high and 6 ticks low in both speed modes. It is unaffected by the speed input.
- R2: In fast mode (`speed_fast` = 1), `cpu_clk` has a period of 6 ticks. It is high for 2 ticks and low for 4.
- R3: `cpu_clk50` has the same period as `cpu_clk` and is high for its first half. It rises only in the same cycle as `cpu_clk` rises, and it is still high whenever `cpu_clk` falls.
- R4: In slow mode (`speed_fast` = 0), every `cpu_clk` and `cpu_clk50` phase length is multiplied by SLOW_DIV.
- R5: `speed_fast` passes through two flip-flops before the mode logic sees it. A value of 1 requests fast mode and a value of 0 requests slow mode.
- R6: The mode changes only at a tick where `per_clk` toggles and the synchronised request differs from the current mode. At that tick, the pair's current phase restarts with the new mode's length. The pair has three phases, in order: both high, then only `cpu_clk50` high, then both low.
- R7: No `cpu_clk` high pulse is shorter than 2 ticks and no low pulse is shorter than 4 ticks. No `cpu_clk50` pulse of either level is shorter than 3 ticks. These minimums hold across mode switches.
- R8: `strap_ext` is registered. When the registered value is 1, `ext_en` is the tick source; when it is 0, `xtal_en` is the tick source. The unselected enable has no effect on `cpu_clk`, `cpu_clk50` or `per_clk`.
- R9: `osc_out` toggles at every cycle in which `xtal_en` is high, whatever `strap_ext` selects.
- R10: While the synchronous reset `rst` is high, all outputs are low, the mode is fast and the strap register holds 0. The first tick after reset raises `per_clk`, `cpu_clk` and `cpu_clk50` together.
- R11: In a cycle with no tick, `cpu_clk`, `cpu_clk50` and `per_clk` hold their values, even when `speed_fast` changes.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strap_ext | input | 1 | Source strap: 1 selects `ext_en`, 0 selects `xtal_en` |
| xtal_en | input | 1 | Crystal-path half-period enable |
| ext_en | input | 1 | External-clock half-period enable |
| speed_fast | input | 1 | Asynchronous speed request: 1 fast, 0 slow |
| cpu_clk | output | 1 | CPU clock, 1/3 duty |
| cpu_clk50 | output | 1 | 50%-duty companion of `cpu_clk` |
| per_clk | output | 1 | Fixed peripheral clock, source/6 |
| osc_out | output | 1 | Buffered square wave of the crystal path |

## Verification
A mode switch can land in the same cycle as a natural phase boundary of the CPU pair, or in the same cycle as the pair's own rising edge. In either case the restart rule and the ordinary count both claim the next count value. The bench provokes this with directed speed toggles placed at each of the twelve offsets within a peripheral period, and with random enables and random toggle times. It judges every cycle against a phase-and-age model of the requirements, and it checks every pulse width against the R7 minimums.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int FAST_HI_TICKS  = 2;
  localparam int FAST_C50_TICKS = 3;
  localparam int FAST_CYC_TICKS = 6;
  localparam int PER_HALF_TICKS = 6;
  localparam int MIN_LO_TICKS   = FAST_CYC_TICKS - FAST_HI_TICKS;
endpackage

// File: rtl/src_select.sv
module src_select (
  input  logic clk,
  input  logic rst,
  input  logic strap_ext,
  input  logic xtal_en,
  input  logic ext_en,
  output logic tick,
  output logic osc_out
);
  logic sel_q;
  logic osc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      osc_q <= 1'b0;
    end else begin
      sel_q <= strap_ext;
      if (xtal_en) osc_q <= ~osc_q;
    end
  end

  assign tick    = sel_q ? ext_en : xtal_en;
  assign osc_out = osc_q;

  // R9: buffered crystal wave moves on every crystal enable
  assert_osc_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    xtal_en |=> (osc_out != $past(osc_out)));
endmodule

// File: rtl/speed_sync.sv
module speed_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic speed_in,
  output logic speed_req
);
  generate
    if (STAGES == 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b1;
        else     s_q <= speed_in;
      end
      assign speed_req = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-2:0], speed_in};
      end
      assign speed_req = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/periph_div.sv
module periph_div #(
  parameter int HALF = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic per_edge,
  output logic per_clk
);
  localparam int W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [W-1:0] LAST = W'(HALF - 1);

  logic [W-1:0] cnt_q;
  logic         per_q;

  assign per_edge = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LAST;
      per_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        per_q <= ~per_q;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  assign per_clk = per_q;

  // R11: no tick, no peripheral edge
  assert_per_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(per_clk));
endmodule

// File: rtl/cpu_div.sv
module cpu_div
  import clkgen_pkg::*;
#(
  parameter int SLOW_DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic per_edge,
  input  logic speed_req,
  output logic cpu_clk,
  output logic cpu_clk50
);
  localparam int SLOW_CYC = FAST_CYC_TICKS * SLOW_DIV;
  localparam int CW       = $clog2(SLOW_CYC + 1);
  typedef logic [CW-1:0] cnt_t;

  function automatic cnt_t hi_len(input logic f);
    return f ? cnt_t'(FAST_HI_TICKS) : cnt_t'(FAST_HI_TICKS * SLOW_DIV);
  endfunction

  function automatic cnt_t c50_len(input logic f);
    return f ? cnt_t'(FAST_C50_TICKS) : cnt_t'(FAST_C50_TICKS * SLOW_DIV);
  endfunction

  function automatic cnt_t cyc_len(input logic f);
    return f ? cnt_t'(FAST_CYC_TICKS) : cnt_t'(SLOW_CYC);
  endfunction

  logic fast_q, cpu_q, c50_q;
  cnt_t cnt_q;
  logic switch_now, mode_n, cpu_d, c50_d;
  cnt_t restart_cnt, natural_cnt, cnt_n;
  logic [2:0] since_q;

  always_comb begin
    switch_now = tick && per_edge && (speed_req != fast_q);
    mode_n     = switch_now ? speed_req : fast_q;
    if (cpu_q && c50_q)  restart_cnt = '0;
    else if (c50_q)      restart_cnt = hi_len(mode_n);
    else                 restart_cnt = c50_len(mode_n);
    natural_cnt = (cnt_q >= cyc_len(fast_q) - cnt_t'(1)) ? '0 : cnt_q + cnt_t'(1);
    cnt_n       = switch_now ? restart_cnt : natural_cnt;
    cpu_d       = cnt_n < hi_len(mode_n);
    c50_d       = cnt_n < c50_len(mode_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q <= 1'b1;
      cnt_q  <= cnt_t'(FAST_CYC_TICKS - 1);
      cpu_q  <= 1'b0;
      c50_q  <= 1'b0;
    end else if (tick) begin
      fast_q <= mode_n;
      cnt_q  <= cnt_n;
      cpu_q  <= cpu_d;
      c50_q  <= c50_d;
    end
  end

  assign cpu_clk   = cpu_q;
  assign cpu_clk50 = c50_q;

  // ticks spent at the present cpu_clk level, saturating
  always_ff @(posedge clk) begin
    if (rst) since_q <= 3'd7;
    else if (tick) begin
      if (cpu_d != cpu_q)     since_q <= 3'd1;
      else if (since_q != 3'd7) since_q <= since_q + 3'd1;
    end
  end

  // R6: mode moves only on a peripheral edge
  assert_switch_on_per_edge_R6: assert property (@(posedge clk) disable iff (rst)
    !(tick && per_edge) |=> (fast_q == $past(fast_q)));
  // R3: companion rises only together with the CPU clock
  assert_c50_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_clk50) |-> $rose(cpu_clk));
  // R3: companion still high when the CPU clock falls
  assert_c50_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_clk) |-> cpu_clk50);
  // R7: minimum high width
  assert_min_high_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && cpu_q && !cpu_d) |-> (since_q >= 3'(FAST_HI_TICKS)));
  // R7: minimum low width
  assert_min_low_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !cpu_q && cpu_d) |-> (since_q >= 3'(MIN_LO_TICKS)));
  // R11: no tick, CPU pair holds
  assert_cpu_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(cpu_clk) && $stable(cpu_clk50)));
endmodule

// File: rtl/dual_speed_clkgen.sv
module dual_speed_clkgen
  import clkgen_pkg::*;
#(
  parameter int SLOW_DIV    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strap_ext,
  input  logic xtal_en,
  input  logic ext_en,
  input  logic speed_fast,
  output logic cpu_clk,
  output logic cpu_clk50,
  output logic per_clk,
  output logic osc_out
);
  logic tick, per_edge, speed_req;

  src_select u_src (
    .clk(clk), .rst(rst), .strap_ext(strap_ext), .xtal_en(xtal_en),
    .ext_en(ext_en), .tick(tick), .osc_out(osc_out)
  );

  speed_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .speed_in(speed_fast), .speed_req(speed_req)
  );

  periph_div #(.HALF(PER_HALF_TICKS)) u_per (
    .clk(clk), .rst(rst), .tick(tick), .per_edge(per_edge), .per_clk(per_clk)
  );

  cpu_div #(.SLOW_DIV(SLOW_DIV)) u_cpu (
    .clk(clk), .rst(rst), .tick(tick), .per_edge(per_edge),
    .speed_req(speed_req), .cpu_clk(cpu_clk), .cpu_clk50(cpu_clk50)
  );
endmodule

// File: tb/sim_dual_speed_clkgen.sv
`timescale 1ns/1ps
module sim_dual_speed_clkgen;
  localparam int SD = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_ext = 1'b0, xtal_en = 1'b0, ext_en = 1'b0, speed_fast = 1'b1;
  logic cpu_clk, cpu_clk50, per_clk, osc_out;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R10";

  always #2 clk = ~clk;

  dual_speed_clkgen #(.SLOW_DIV(SD), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .strap_ext(strap_ext), .xtal_en(xtal_en),
    .ext_en(ext_en), .speed_fast(speed_fast), .cpu_clk(cpu_clk),
    .cpu_clk50(cpu_clk50), .per_clk(per_clk), .osc_out(osc_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", req, tag, $time, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp_min, input int exp_max);
    checks++;
    if (act < exp_min || act > exp_max) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d..%0d", req, tag, $time, act, exp_min, exp_max);
    end
  endtask

  // phase lengths: 0 both high, 1 companion only, 2 both low
  function automatic int plen(input int ph, input bit f);
    int k = f ? 1 : SD;
    return (ph == 0) ? 2 * k : (ph == 1) ? k : 3 * k;
  endfunction

  // reference model of the requirements
  bit m_sel, m_s1, m_s2, m_osc, m_fast, m_per;
  int m_phase, m_age, m_page, tcount;
  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_s1 = 1; m_s2 = 1; m_osc = 0; m_fast = 1;
      m_phase = 2; m_age = 3; m_per = 0; m_page = 6;
    end else begin
      bit t, req, edg;
      t = m_sel ? ext_en : xtal_en;
      req = m_s2;
      if (xtal_en) m_osc = !m_osc;
      if (t) begin
        tcount++;
        edg = (m_page == 6);
        if (edg) begin m_per = !m_per; m_page = 1; end
        else m_page++;
        if (edg && req != m_fast) begin m_fast = req; m_age = 1; end
        else if (m_age >= plen(m_phase, m_fast)) begin m_phase = (m_phase + 1) % 3; m_age = 1; end
        else m_age++;
      end
      m_s2 = m_s1; m_s1 = speed_fast; m_sel = strap_ext;
    end
  end

  // per-cycle comparison and pulse-width checks
  logic p_cpu = 0, p_c50 = 0, p_per = 0;
  int e_cpu = -1, e_c50 = -1, e_per = -1;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 R4 R6 cpu_clk", cpu_clk, m_phase == 0);
      check("R3 R4 cpu_clk50", cpu_clk50, m_phase != 2);
      check("R1 per_clk", per_clk, m_per);
      check("R9 osc_out", osc_out, m_osc);
      if (per_clk != p_per) begin
        if (e_per >= 0) check_int("R1 per width", tcount - e_per, 6, 6);
        e_per = tcount;
      end
      if (cpu_clk != p_cpu) begin
        if (e_cpu >= 0) check_int(cpu_clk ? "R7 cpu low" : "R7 cpu high",
                                  tcount - e_cpu, cpu_clk ? 4 : 2, 1 << 20);
        e_cpu = tcount;
      end
      if (cpu_clk50 != p_c50) begin
        if (e_c50 >= 0) check_int("R7 c50 width", tcount - e_c50, 3, 1 << 20);
        if (cpu_clk50) check("R3 c50 rises with cpu", cpu_clk && !p_cpu, 1'b1);
        e_c50 = tcount;
      end
      p_cpu = cpu_clk; p_c50 = cpu_clk50; p_per = per_clk;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic h_cpu, h_c50, h_per;
    void'($urandom(32'd20240611));
    cycles(4);
    tag = "R10";
    check("R10 reset cpu_clk", cpu_clk, 1'b0);
    check("R10 reset cpu_clk50", cpu_clk50, 1'b0);
    check("R10 reset per_clk", per_clk, 1'b0);
    check("R10 reset osc_out", osc_out, 1'b0);
    rst = 1'b0; xtal_en = 1'b1;
    @(negedge clk);
    check("R10 first tick cpu_clk", cpu_clk, 1'b1);
    check("R10 first tick cpu_clk50", cpu_clk50, 1'b1);
    check("R10 first tick per_clk", per_clk, 1'b1);
    tag = "R2"; cycles(60);
    tag = "R4"; speed_fast = 1'b0; cycles(200);
    tag = "R5"; speed_fast = 1'b1; cycles(100);
    tag = "R6";
    for (int off = 0; off < 12; off++) begin
      cycles(off + 1); speed_fast = 1'b0; cycles(80);
      cycles(off + 1); speed_fast = 1'b1; cycles(40);
    end
    tag = "R11";
    xtal_en = 1'b0; cycles(1);
    h_cpu = cpu_clk; h_c50 = cpu_clk50; h_per = per_clk;
    speed_fast = 1'b0; cycles(20); speed_fast = 1'b1; cycles(10);
    check("R11 hold cpu_clk", cpu_clk, h_cpu);
    check("R11 hold cpu_clk50", cpu_clk50, h_c50);
    check("R11 hold per_clk", per_clk, h_per);
    tag = "R8";
    strap_ext = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      ext_en = ($urandom % 4) != 0;
      xtal_en = $urandom % 2;
      if ($urandom % 97 == 0) speed_fast = ~speed_fast;
      @(negedge clk);
    end
    strap_ext = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      xtal_en = ($urandom % 3) != 0;
      ext_en = $urandom % 2;
      if ($urandom % 89 == 0) speed_fast = ~speed_fast;
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule